// File: doc/BRIEF.md
# Flash Program/Erase Status Flag Reporter

This block sits on the read path of an embedded flash array. When no automatic operation is running, a read returns the array byte unchanged. While a program or erase operation is running, a read returns a status byte instead. Software can tell from that byte three things: whether the operation is still running, whether it is programming or erasing, and whether it has run past its time limit.

The controller is a five-state machine:
- `ST_IDLE` is the read/reset state.
- `ST_PROG` and `ST_ERASE` are the two busy states.
- `ST_PROG_OVER` and `ST_ERASE_OVER` are the busy states after the timer has reported an overrun.

The transitions are:
- *start*: from `ST_IDLE` to a busy state, on an accepted start request.
- *overrun*: from a busy state to its over state, on `time_over`.
- *finish*: from a busy state to `ST_IDLE`, on `op_done`.
- *abort*: from any state to `ST_IDLE`, on `reset_cmd`.

Two toggle flip-flops are cleared on *start* and are inverted by reads. The first toggle is inverted by every read during any busy state. The second is inverted only in the erase states. Alongside the status byte, a level output `ready` lets software poll for completion without reading the array.

Top module: `flash_status_reporter`

## Requirements
- R1: In `ST_IDLE`, a read (`rd_stb`=1) loads `array_data` unchanged into `rd_data`, and `ready` is 1.
- R2: In a program state, a read returns at bit 7 the inverse of bit 7 of the `prog_data` value captured at start.
- R3: In an erase state, a read returns 0 at bit 7.
- R4: In any busy state, bit 6 of a read is 0 on the first read after start and alternates on every later read.
- R5: Bit 2 of a read is 1 in program states. In erase states it is 0 on the first read after start and alternates on every later read.
- R6: Bit 5 of a read is 0 until `time_over` is seen in a busy state, and 1 from then on. The timeout is sticky: `op_done` is ignored while it is set.
- R7: `op_done` in `ST_PROG` or `ST_ERASE`, with no `time_over` in that cycle, returns the block to `ST_IDLE`. A simultaneous `time_over` takes priority over `op_done`.
- R8: `reset_cmd` returns the block to `ST_IDLE` from every state, clears the timeout, and takes priority over a start in the same cycle.
- R9: Bits 4, 3, 1 and 0 of a status read are 0.
- R10: `rd_data` is registered. It changes only in the cycle after a read strobe and holds otherwise. It is 0 after reset.
- R11: A start is accepted only in `ST_IDLE`, when `op_start`=1 and `op_kind` is 2'b01 (program) or 2'b10 (erase). Codes 2'b00 and 2'b11 are ignored, and a start while busy is ignored.
- R12: `ready` is 0 in all four busy states and 1 in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start request pulse from the command decoder |
| op_kind | input | 2 | Operation type: 01 program, 10 erase, others none |
| prog_data | input | 8 | Byte being programmed, captured on start |
| array_data | input | 8 | Byte read from the array |
| rd_stb | input | 1 | Read access strobe, one per clock at most |
| time_over | input | 1 | Operation timer overrun indication |
| op_done | input | 1 | Operation finished pulse |
| reset_cmd | input | 1 | Reset command pulse |
| rd_data | output | 8 | Registered read data or status byte |
| ready | output | 1 | 1 when no operation is running |

## Verification
The bench builds the block with its default parameters:
- flag bits at positions 7, 6, 5 and 2;
- two toggle flip-flops, the upper one active only during erase.

With these values, every field position the requirements name is observable at the ports.

A behavioural reference model predicts `rd_data` and `ready` on every clock. The stimulus reaches every state and transition, including:
- the collisions of `time_over` with `op_done`;
- `reset_cmd` arriving together with a start;
- runs of idle cycles between reads, which expose the hold behaviour.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_PROG_OVER,
        ST_ERASE_OVER
    } fsr_state_e;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'b00,
        OPK_PROG  = 2'b01,
        OPK_ERASE = 2'b10,
        OPK_RSVD  = 2'b11
    } fsr_opk_e;

endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic       time_over,
    input  logic       op_done,
    input  logic       reset_cmd,
    output logic       start_acc,
    output logic       busy,
    output logic       erase_mode,
    output logic       over,
    output logic       ready
);

    fsr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (reset_cmd) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (op_start && (op_kind == OPK_PROG)) begin
                        state_d = ST_PROG;
                    end else if (op_start && (op_kind == OPK_ERASE)) begin
                        state_d = ST_ERASE;
                    end
                end
                ST_PROG: begin
                    if (time_over) begin
                        state_d = ST_PROG_OVER;
                    end else if (op_done) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_ERASE: begin
                    if (time_over) begin
                        state_d = ST_ERASE_OVER;
                    end else if (op_done) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_PROG_OVER:  state_d = ST_PROG_OVER;
                ST_ERASE_OVER: state_d = ST_ERASE_OVER;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        start_acc  = 1'b0;
        busy       = 1'b1;
        erase_mode = 1'b0;
        over       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                start_acc = op_start && !reset_cmd &&
                            ((op_kind == OPK_PROG) || (op_kind == OPK_ERASE));
            end
            ST_PROG: begin
            end
            ST_ERASE: begin
                erase_mode = 1'b1;
            end
            ST_PROG_OVER: begin
                over = 1'b1;
            end
            ST_ERASE_OVER: begin
                erase_mode = 1'b1;
                over       = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        ready = !busy;
    end

    // R6: timeout holds until reset command
    p_over_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (over && !reset_cmd) |=> over);

    // R7: finish returns to idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !over && op_done && !time_over && !reset_cmd) |=> ready);

    // R8: abort from anywhere
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> (ready && !over));

    // R11: start ignored while busy
    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reset_cmd && !op_done) |=> busy);

endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle #(
    parameter int              NTOG       = 2,
    parameter logic [NTOG-1:0] ERASE_ONLY = 2'b10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_acc,
    input  logic            rd_stb,
    input  logic            busy,
    input  logic            erase_mode,
    output logic [NTOG-1:0] tog
);

    for (genvar i = 0; i < NTOG; i++) begin : g_tog
        logic flip_en;

        if (ERASE_ONLY[i]) begin : g_erase
            assign flip_en = rd_stb && busy && erase_mode;
        end else begin : g_any
            assign flip_en = rd_stb && busy;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tog[i] <= 1'b0;
            end else if (start_acc) begin
                tog[i] <= 1'b0;
            end else if (flip_en) begin
                tog[i] <= ~tog[i];
            end
        end

        // R4: toggle unchanged without a read
        p_tog_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_stb && !start_acc) |=> $stable(tog[i]));
    end

endmodule

// File: rtl/fsr_format.sv
module fsr_format #(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6,
    parameter int TMO_BIT  = 5,
    parameter int TOG2_BIT = 2,
    parameter int NTOG     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              start_acc,
    input  logic              busy,
    input  logic              erase_mode,
    input  logic              over,
    input  logic [NTOG-1:0]   tog,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] DEF_MASK =
        (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT) |
        (DATA_W'(1) << TMO_BIT)  | (DATA_W'(1) << TOG2_BIT);

    logic              poll_q;
    logic [DATA_W-1:0] status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_q <= 1'b0;
        end else if (start_acc) begin
            poll_q <= ~prog_data[POLL_BIT];
        end
    end

    always_comb begin
        status           = '0;
        status[POLL_BIT] = erase_mode ? 1'b0 : poll_q;
        status[TOG_BIT]  = tog[0];
        status[TMO_BIT]  = over;
        status[TOG2_BIT] = erase_mode ? tog[NTOG-1] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= busy ? status : array_data;
        end
    end

    // R9: undefined positions stay zero on status reads
    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> ((rd_data & ~DEF_MASK) == '0));

    // R10: output holds without a read
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R3: erase polling bit reads zero
    p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && erase_mode) |=> !rd_data[POLL_BIT]);

    // R5: program second toggle reads one
    p_prog_tog2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && !erase_mode) |=> rd_data[TOG2_BIT]);

endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter #(
    parameter int DATA_W   = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6,
    parameter int TMO_BIT  = 5,
    parameter int TOG2_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [DATA_W-1:0] array_data,
    input  logic              rd_stb,
    input  logic              time_over,
    input  logic              op_done,
    input  logic              reset_cmd,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);

    localparam int              NTOG       = 2;
    localparam logic [NTOG-1:0] ERASE_ONLY = 2'b10;

    logic            start_acc;
    logic            busy;
    logic            erase_mode;
    logic            over;
    logic [NTOG-1:0] tog;

    fsr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_kind    (op_kind),
        .time_over  (time_over),
        .op_done    (op_done),
        .reset_cmd  (reset_cmd),
        .start_acc  (start_acc),
        .busy       (busy),
        .erase_mode (erase_mode),
        .over       (over),
        .ready      (ready)
    );

    fsr_toggle #(
        .NTOG       (NTOG),
        .ERASE_ONLY (ERASE_ONLY)
    ) u_toggle (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_acc  (start_acc),
        .rd_stb     (rd_stb),
        .busy       (busy),
        .erase_mode (erase_mode),
        .tog        (tog)
    );

    fsr_format #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT),
        .TMO_BIT  (TMO_BIT),
        .TOG2_BIT (TOG2_BIT),
        .NTOG     (NTOG)
    ) u_format (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .start_acc  (start_acc),
        .busy       (busy),
        .erase_mode (erase_mode),
        .over       (over),
        .tog        (tog),
        .prog_data  (prog_data),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    // R1: idle read passes array byte
    p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ready) |=> (rd_data == $past(array_data)));

    // R12: timeout implies not ready
    p_over_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        over |-> !ready);

endmodule

// File: tb/flash_status_reporter_test.sv
module flash_status_reporter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic [7:0] prog_data = 8'h00;
    logic [7:0] array_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic       time_over = 1'b0;
    logic       op_done = 1'b0;
    logic       reset_cmd = 1'b0;
    logic [7:0] rd_data;
    logic       ready;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_status_reporter uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .prog_data(prog_data), .array_data(array_data), .rd_stb(rd_stb),
        .time_over(time_over), .op_done(op_done), .reset_cmd(reset_cmd),
        .rd_data(rd_data), .ready(ready)
    );

    // reference model: 0 idle, 1 program, 2 erase
    int       m_st = 0;
    bit       m_over = 0, m_t6 = 0, m_t2 = 0, m_poll = 0;
    bit [7:0] m_out = 0;
    int       m_rd_st = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_over = 0; m_t6 = 0; m_t2 = 0; m_poll = 0;
            m_out = 0; m_rd_st = 0;
        end else begin
            if (rd_stb) begin
                m_rd_st = m_st;
                if (m_st == 0) begin
                    m_out = array_data;
                end else begin
                    m_out = 8'h00;
                    m_out[7] = (m_st == 2) ? 1'b0 : m_poll;
                    m_out[6] = m_t6;
                    m_out[5] = m_over;
                    m_out[2] = (m_st == 2) ? m_t2 : 1'b1;
                    m_t6 = !m_t6;
                    if (m_st == 2) m_t2 = !m_t2;
                end
            end
            if (reset_cmd) begin
                m_st = 0; m_over = 0;
            end else if (m_st == 0) begin
                if (op_start && (op_kind == 2'b01 || op_kind == 2'b10)) begin
                    m_st = int'(op_kind);
                    m_poll = !prog_data[7];
                    m_t6 = 0; m_t2 = 0;
                end
            end else if (time_over) begin
                m_over = 1;
            end else if (op_done && !m_over) begin
                m_st = 0;
            end
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        check("R12", {7'd0, ready}, {7'd0, (m_st == 0)});
        if (m_rd_st == 0) begin
            check("R1", rd_data, m_out);
        end else begin
            check((m_rd_st == 2) ? "R3" : "R2", {7'd0, rd_data[7]}, {7'd0, m_out[7]});
            check("R4", {7'd0, rd_data[6]}, {7'd0, m_out[6]});
            check("R6", {7'd0, rd_data[5]}, {7'd0, m_out[5]});
            check("R5", {7'd0, rd_data[2]}, {7'd0, m_out[2]});
            check("R9", {4'd0, rd_data[4:3], rd_data[1:0]}, 8'd0);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic rd(input logic [7:0] a);
        array_data = a; rd_stb = 1'b1; cyc(); rd_stb = 1'b0;
    endtask

    task automatic start(input logic [1:0] k, input logic [7:0] d);
        op_start = 1'b1; op_kind = k; prog_data = d; cyc();
        op_start = 1'b0; op_kind = 2'b00;
    endtask

    task automatic pulse_done();
        op_done = 1'b1; cyc(); op_done = 1'b0;
    endtask

    task automatic pulse_tmo();
        time_over = 1'b1; cyc(); time_over = 1'b0;
    endtask

    task automatic pulse_rst();
        reset_cmd = 1'b1; cyc(); reset_cmd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: reset state
        check("R10", rd_data, 8'h00);
        check("R12", {7'd0, ready}, 8'd1);

        // R1: idle pass-through, several patterns
        rd(8'hA5); rd(8'h5A); cyc(); cyc();
        check("R10", rd_data, 8'h5A);
        rd(8'hFF); rd(8'h00);

        // R11: ignored start codes
        start(2'b00, 8'h00); start(2'b11, 8'h00);
        check("R11", {7'd0, ready}, 8'd1);

        // program, data bit7=1 -> poll 0
        start(2'b01, 8'h80);
        for (int i = 0; i < 5; i++) begin
            rd(8'h33); cyc();
        end
        start(2'b10, 8'h00);   // R11: ignored while busy
        rd(8'h33);
        check("R11", rd_data[2] ? 8'd1 : 8'd0, 8'd1);
        pulse_done();
        check("R7", {7'd0, ready}, 8'd1);
        rd(8'hC3);
        check("R7", rd_data, 8'hC3);

        // program with timeout, data bit7=0 -> poll 1
        start(2'b01, 8'h3C);
        rd(8'h00); rd(8'h00);
        pulse_tmo();
        rd(8'h00);
        check("R6", {7'd0, rd_data[5]}, 8'd1);
        pulse_done();          // R6: ignored while over
        check("R6", {7'd0, ready}, 8'd0);
        rd(8'h00); rd(8'h00);
        pulse_rst();
        check("R8", {7'd0, ready}, 8'd1);
        rd(8'h99);

        // erase
        start(2'b10, 8'hFF);
        for (int i = 0; i < 6; i++) rd(8'h11);
        time_over = 1'b1; op_done = 1'b1; cyc();   // R7: timeout wins
        time_over = 1'b0; op_done = 1'b0;
        check("R7", {7'd0, ready}, 8'd0);
        rd(8'h11); rd(8'h11); cyc(); rd(8'h11);
        pulse_rst();
        rd(8'h77);

        // erase, plain finish
        start(2'b10, 8'h00);
        rd(8'h22); rd(8'h22); rd(8'h22);
        pulse_done();
        rd(8'h44);
        check("R7", rd_data, 8'h44);

        // R8: reset command beats a start in the same cycle
        reset_cmd = 1'b1; op_start = 1'b1; op_kind = 2'b01; cyc();
        reset_cmd = 1'b0; op_start = 1'b0; op_kind = 2'b00;
        check("R8", {7'd0, ready}, 8'd1);

        // R8: abort from busy without timeout, then restart clears toggles
        start(2'b01, 8'h00);
        rd(8'h00);
        pulse_rst();
        check("R8", {7'd0, ready}, 8'd1);
        start(2'b10, 8'h00);
        rd(8'h00);
        check("R4", {7'd0, rd_data[6]}, 8'd0);
        check("R5", {7'd0, rd_data[2]}, 8'd0);
        pulse_done();
        cyc();
        finish_run();
    end

endmodule